// File: doc/BRIEF.md
# DMA Control Register Write Sequencer

This block is the programming front end of a DMA controller. A host CPU writes bytes one at a time on an 8-bit bus with a single-cycle write strobe. A byte that arrives when no parameter bytes are outstanding is a base byte. The decoder sorts it into one of six mode registers or treats it as a one-byte command. Flag bits in a mode-register byte select which parameter bytes follow. The block then expects exactly those bytes, in a fixed ascending order, and files each one into the register it belongs to. An interrupt-control parameter byte can itself extend the sequence with pulse-control and vector bytes.

Commands act on the rest of the state. They reload the working address and byte counters, set or clear the enable, force-ready and interrupt-enable flags, OR bits into the status byte, and clear timing bytes. A column-wise soft reset clears one slice of the parameter store per command. A read mask selects counter and address bytes for a read-back queue, which the host drains with a read strobe.

The transfer engine, bus arbitration and interrupt chaining are outside this block. They consume its registered outputs.

Top module: `dma_regseq`

## Requirements
- R1: With nothing pending, a written byte is classified in priority order. (d & 0x87)==0x00 is mode register 2. (d & 0x87)==0x04 is mode register 1. Any other byte with bit 7 clear is mode register 0. (d & 0x83)==0x80 is mode register 3. (d & 0x83)==0x81 is mode register 4. (d & 0xC7)==0x82 is mode register 5. (d & 0x83)==0x83 is a command. Mode register k is visible as byte k of `mode_regs` (bits 8k+7..8k).
- R2: In a mode-register-0 byte, bits 3, 4, 5 and 6 each request one following byte. The requested bytes arrive in that bit order and fill port A address low, port A address high, block length low and block length high. Bytes that are not requested are skipped.
- R3: Bit 6 of a mode-register-1 byte requests one byte for `timing_a`. Bit 6 of a mode-register-2 byte requests one byte for `timing_b`.
- R4: In mode register 3, bit 3 requests `mask_byte` and bit 4 requests `match_byte`, in that order. In mode register 4, bits 2, 3 and 4 request port B address low, port B address high and `int_ctrl`, in that order.
- R5: When an `int_ctrl` byte is stored, the rest of the pending list is discarded. Bit 3 of the stored byte then requests `pulse_ctrl` and bit 4 requests `int_vector`, in that order. When the list runs out, the next byte is decoded as a base byte.
- R6: Every command clears `dma_enable` before it acts. 0x87 sets `dma_enable`, 0x83 leaves it clear, and 0xB3 sets `force_ready`.
- R7: Load (0xCF) copies both port addresses into `work_addr_a` and `work_addr_b` and the block length into `work_count`. It also clears `force_ready` and ORs 0x30 into `status`.
- R8: Continue (0xD3) reloads only `work_count` from the block length. It sets `dma_enable` and ORs 0x30 into `status`. The address counters are left unchanged.
- R9: Reset (0xC3) clears `dma_enable` and `force_ready`, sets `status` to 0x38 and zeroes one column of the register store. Column 0 holds the mode bytes. Column c≥1 holds the c-th parameter slot of every mode register, and slot 1 of the command row is the read mask.
  - A column pointer picks the column.
  - The pointer advances (5 wraps to 0) after each Reset and each parameter byte.
  - Any other base byte returns the pointer to 0.
- R10: 0xAB sets bit 5 of mode register 3 (`irq_enable`) and 0xAF clears it. 0xA3 clears it, clears `force_ready` and ORs 0x08 into `status`.
- R11: Read-back works as follows.
  - 0xBB makes the next byte the read mask, and 0xBF clears the mask.
  - 0xA7 builds a queue from the mask bits 0 to 6. In that order the bits select status, count low, count high, A address low, A address high, B address low and B address high.
  - Each `rd_en` pulse returns the next queue entry on `rd_data` one cycle later, wrapping to the first entry. With an empty queue it returns `status`.
  - A read in the same cycle as a write sees the state from before that write.
- R12: Command code 0xB7, any other unlisted command code, and any byte that fits no rule of R1 set the sticky `cmd_error`. Such a byte changes nothing else except clearing `dma_enable`. 0xFB is accepted with no effect beyond clearing `dma_enable`.
- R13: 0xC7 clears `timing_a`, 0xCB clears `timing_b`, and 0x8B ORs 0x30 into `status`.
- R14: After `rst`, all registers, flags, counters and `status` are zero, the read queue is empty and no parameter bytes are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Read strobe for the read-back queue |
| rd_data | output | 8 | Read-back byte, valid the cycle after `rd_en` |
| dma_enable | output | 1 | Transfer enable flag |
| force_ready | output | 1 | Force-ready flag |
| irq_enable | output | 1 | Interrupt enable (mode register 3 bit 5) |
| cmd_error | output | 1 | Sticky flag for unknown bytes or commands |
| status | output | 8 | Status byte |
| work_addr_a | output | 16 | Working port A address |
| work_addr_b | output | 16 | Working port B address |
| work_count | output | 16 | Working byte counter |
| mode_regs | output | 48 | Mode registers 0 to 5, byte k = register k |
| timing_a | output | 8 | Port A timing byte |
| timing_b | output | 8 | Port B timing byte |
| mask_byte | output | 8 | Search mask byte |
| match_byte | output | 8 | Search match byte |
| int_ctrl | output | 8 | Interrupt control byte |
| pulse_ctrl | output | 8 | Pulse control byte |
| int_vector | output | 8 | Interrupt vector byte |

## Verification
Two functions can land on the same clock edge: a read strobe and a write that changes what the read would return. The bench pulses `rd_en` in the same cycle as a Load that rewrites `status`, and in the same cycle as an Initiate-read that rebuilds the queue. It expects the old status value in the first case and the old queue contents in the second. A follow-up read must then show the new value. The same edge-sharing happens inside the register store, where a Reset column clear and a mode-byte write could both target column 0. The column sweep checks that a Reset clears only its own column and leaves the other parameter bytes alone.

// File: rtl/dma_regseq_pkg.sv
package dma_regseq_pkg;
  localparam int DW       = 8;   // bus byte width
  localparam int NBASE    = 6;   // mode registers 0..5
  localparam int NROW     = 7;   // mode rows plus command row
  localparam int NCOL     = 6;   // base byte plus five parameter slots
  localparam int RQ_DEPTH = 7;   // read-back entries
  localparam int RW       = $clog2(NROW);
  localparam int CW       = $clog2(NCOL);

  typedef enum logic [2:0] {
    K_R0, K_R1, K_R2, K_R3, K_R4, K_R5, K_CMD, K_BAD
  } kind_t;

  // rows of the parameter store
  localparam logic [RW-1:0] ROW_M0   = 3'd0;
  localparam logic [RW-1:0] ROW_M1   = 3'd1;
  localparam logic [RW-1:0] ROW_M2   = 3'd2;
  localparam logic [RW-1:0] ROW_M3   = 3'd3;
  localparam logic [RW-1:0] ROW_M4   = 3'd4;
  localparam logic [RW-1:0] ROW_M5   = 3'd5;
  localparam logic [RW-1:0] ROW_CMD  = 3'd6;
  // column of the interrupt-control slot in row 4 (sequence extension point)
  localparam logic [CW-1:0] COL_ICTL = 3'd3;
  localparam int            COL_PLS  = 4;
  localparam int            COL_VEC  = 5;

  // command codes
  localparam logic [DW-1:0] C_RESET  = 8'hC3;
  localparam logic [DW-1:0] C_RST_TA = 8'hC7;
  localparam logic [DW-1:0] C_RST_TB = 8'hCB;
  localparam logic [DW-1:0] C_LOAD   = 8'hCF;
  localparam logic [DW-1:0] C_CONT   = 8'hD3;
  localparam logic [DW-1:0] C_DIS    = 8'h83;
  localparam logic [DW-1:0] C_EN     = 8'h87;
  localparam logic [DW-1:0] C_IEN    = 8'hAB;
  localparam logic [DW-1:0] C_IDIS   = 8'hAF;
  localparam logic [DW-1:0] C_IRDIS  = 8'hA3;
  localparam logic [DW-1:0] C_RDSEQ  = 8'hA7;
  localparam logic [DW-1:0] C_FRDY   = 8'hB3;
  localparam logic [DW-1:0] C_REINIT = 8'h8B;
  localparam logic [DW-1:0] C_RMASK  = 8'hBB;
  localparam logic [DW-1:0] C_RDSTAT = 8'hBF;
  localparam logic [DW-1:0] C_NOP    = 8'hFB;

  typedef struct packed {
    logic [NBASE-1:0][DW-1:0] base;
    logic [DW-1:0] a_lo, a_hi, len_lo, len_hi;
    logic [DW-1:0] tim_a, tim_b, msk, mtc;
    logic [DW-1:0] b_lo, b_hi, ictl, pulse, vec;
    logic [RQ_DEPTH-1:0] rmask;
  } cfg_t;
endpackage

// File: rtl/dma_regseq_decode.sv
module dma_regseq_decode
  import dma_regseq_pkg::*;
(
  input  logic [DW-1:0] d,
  output kind_t         kind
);
  always_comb begin
    if      ((d & 8'h87) == 8'h00) kind = K_R2;
    else if ((d & 8'h87) == 8'h04) kind = K_R1;
    else if (!d[7])                kind = K_R0;
    else if ((d & 8'h83) == 8'h80) kind = K_R3;
    else if ((d & 8'h83) == 8'h81) kind = K_R4;
    else if ((d & 8'hC7) == 8'h82) kind = K_R5;
    else if ((d & 8'h83) == 8'h83) kind = K_CMD;
    else                           kind = K_BAD;
  end
endmodule

// File: rtl/dma_regseq_regfile.sv
module dma_regseq_regfile
  import dma_regseq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] wrow,
  input  logic [CW-1:0] wcol,
  input  logic [DW-1:0] wdata,
  input  logic          clr_en,
  input  logic [CW-1:0] clr_col,
  output cfg_t          cfg
);
  logic [DW-1:0] mem [NROW][NCOL];

  always_ff @(posedge clk) begin
    for (int r = 0; r < NROW; r++) begin
      for (int c = 0; c < NCOL; c++) begin
        if (rst)
          mem[r][c] <= '0;
        else if (clr_en && c == int'(clr_col))
          mem[r][c] <= '0;
        else if (we && r == int'(wrow) && c == int'(wcol))
          mem[r][c] <= wdata;
      end
    end
  end

  for (genvar b = 0; b < NBASE; b++) begin : g_base
    assign cfg.base[b] = mem[b][0];
  end

  assign cfg.a_lo   = mem[0][1];
  assign cfg.a_hi   = mem[0][2];
  assign cfg.len_lo = mem[0][3];
  assign cfg.len_hi = mem[0][4];
  assign cfg.tim_a  = mem[1][1];
  assign cfg.tim_b  = mem[2][1];
  assign cfg.msk    = mem[3][1];
  assign cfg.mtc    = mem[3][2];
  assign cfg.b_lo   = mem[4][1];
  assign cfg.b_hi   = mem[4][2];
  assign cfg.ictl   = mem[4][3];
  assign cfg.pulse  = mem[4][4];
  assign cfg.vec    = mem[4][5];
  assign cfg.rmask  = mem[6][1][RQ_DEPTH-1:0];
endmodule

// File: rtl/dma_regseq_readq.sv
module dma_regseq_readq
  import dma_regseq_pkg::*;
#(
  parameter int DEPTH = RQ_DEPTH
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [DEPTH-1:0][DW-1:0]   vals,
  input  logic [DEPTH-1:0]           sel,
  input  logic                       rd_en,
  input  logic [DW-1:0]              fallback,
  output logic [DW-1:0]              rd_data
);
  localparam int NW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][DW-1:0] q, q_pack;
  logic [NW-1:0]            cnt, cnt_pack, ptr;

  always_comb begin
    int n;
    n      = 0;
    q_pack = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel[i]) begin
        q_pack[n] = vals[i];
        n++;
      end
    end
    cnt_pack = NW'(n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= '0;
      cnt     <= '0;
      ptr     <= '0;
      rd_data <= '0;
    end else begin
      if (rd_en) begin
        rd_data <= (cnt == '0) ? fallback : q[ptr];
        if (cnt != '0) ptr <= (ptr + 1'b1 == cnt) ? '0 : ptr + 1'b1;
      end
      if (load) begin
        q   <= q_pack;
        cnt <= cnt_pack;
        ptr <= '0;
      end
    end
  end

  // R11
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) ? (ptr == '0) : (ptr < cnt));
endmodule

// File: rtl/dma_regseq.sv
module dma_regseq
  import dma_regseq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic                rd_en,
  output logic [7:0]          rd_data,
  output logic                dma_enable,
  output logic                force_ready,
  output logic                irq_enable,
  output logic                cmd_error,
  output logic [7:0]          status,
  output logic [15:0]         work_addr_a,
  output logic [15:0]         work_addr_b,
  output logic [15:0]         work_count,
  output logic [47:0]         mode_regs,
  output logic [7:0]          timing_a,
  output logic [7:0]          timing_b,
  output logic [7:0]          mask_byte,
  output logic [7:0]          match_byte,
  output logic [7:0]          int_ctrl,
  output logic [7:0]          pulse_ctrl,
  output logic [7:0]          int_vector
);
  localparam int WW = 2 * DW;

  kind_t          kind;
  cfg_t           cfg;
  logic [RW-1:0]  pend_row, pend_row_n;
  logic [NCOL-1:0] pend_mask, pend_mask_n;
  logic [CW-1:0]  rptr, rptr_n, pcol;
  logic [DW-1:0]  stat_q, stat_n;
  logic           en_q, en_n, frdy_q, frdy_n, err_q, err_n;
  logic [WW-1:0]  wa_q, wa_n, wb_q, wb_n, wc_q, wc_n;
  logic           busy, rf_we, clr_en, rq_load;
  logic [RW-1:0]  rf_row;
  logic [CW-1:0]  rf_col;
  logic [DW-1:0]  rf_wd;
  logic [RQ_DEPTH-1:0][DW-1:0] rq_vals;

  function automatic logic [CW-1:0] ptr_adv(input logic [CW-1:0] p);
    return (p == CW'(NCOL - 1)) ? '0 : p + 1'b1;
  endfunction

  dma_regseq_decode u_dec (.d(wr_data), .kind(kind));

  dma_regseq_regfile u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .wrow(rf_row), .wcol(rf_col),
    .wdata(rf_wd), .clr_en(clr_en), .clr_col(rptr), .cfg(cfg)
  );

  assign rq_vals[0] = stat_q;
  assign rq_vals[1] = wc_q[DW-1:0];
  assign rq_vals[2] = wc_q[WW-1:DW];
  assign rq_vals[3] = wa_q[DW-1:0];
  assign rq_vals[4] = wa_q[WW-1:DW];
  assign rq_vals[5] = wb_q[DW-1:0];
  assign rq_vals[6] = wb_q[WW-1:DW];

  dma_regseq_readq u_rq (
    .clk(clk), .rst(rst), .load(rq_load), .vals(rq_vals), .sel(cfg.rmask),
    .rd_en(rd_en), .fallback(stat_q), .rd_data(rd_data)
  );

  assign busy = |pend_mask;

  // next parameter slot: lowest pending column
  always_comb begin
    pcol = '0;
    for (int c = NCOL - 1; c >= 0; c--)
      if (pend_mask[c]) pcol = CW'(c);
  end

  always_comb begin
    pend_row_n  = pend_row;
    pend_mask_n = pend_mask;
    rptr_n      = rptr;
    stat_n      = stat_q;
    en_n        = en_q;
    frdy_n      = frdy_q;
    err_n       = err_q;
    wa_n        = wa_q;
    wb_n        = wb_q;
    wc_n        = wc_q;
    rf_we       = 1'b0;
    rf_row      = '0;
    rf_col      = '0;
    rf_wd       = '0;
    clr_en      = 1'b0;
    rq_load     = 1'b0;
    if (wr_en) begin
      if (busy) begin
        rf_we       = 1'b1;
        rf_row      = pend_row;
        rf_col      = pcol;
        rf_wd       = wr_data;
        pend_mask_n = pend_mask & ~(NCOL'(1) << pcol);
        if (pend_row == ROW_M4 && pcol == COL_ICTL) begin
          pend_mask_n          = '0;
          pend_mask_n[COL_PLS] = wr_data[3];
          pend_mask_n[COL_VEC] = wr_data[4];
        end
        rptr_n = ptr_adv(rptr);
      end else begin
        rptr_n      = '0;
        pend_mask_n = '0;
        rf_wd       = wr_data;
        unique case (kind)
          K_R0: begin
            rf_we = 1'b1; rf_row = ROW_M0; pend_row_n = ROW_M0;
            pend_mask_n[4:1] = wr_data[6:3];
          end
          K_R1: begin
            rf_we = 1'b1; rf_row = ROW_M1; pend_row_n = ROW_M1;
            pend_mask_n[1] = wr_data[6];
          end
          K_R2: begin
            rf_we = 1'b1; rf_row = ROW_M2; pend_row_n = ROW_M2;
            pend_mask_n[1] = wr_data[6];
          end
          K_R3: begin
            rf_we = 1'b1; rf_row = ROW_M3; pend_row_n = ROW_M3;
            pend_mask_n[2:1] = wr_data[4:3];
          end
          K_R4: begin
            rf_we = 1'b1; rf_row = ROW_M4; pend_row_n = ROW_M4;
            pend_mask_n[3:1] = wr_data[4:2];
          end
          K_R5: begin
            rf_we = 1'b1; rf_row = ROW_M5;
          end
          K_CMD: begin
            en_n = 1'b0;
            case (wr_data)
              C_RESET: begin
                frdy_n = 1'b0; stat_n = 8'h38; clr_en = 1'b1;
                rptr_n = ptr_adv(rptr);
              end
              C_RST_TA: begin rf_we = 1'b1; rf_row = ROW_M1; rf_col = 3'd1; rf_wd = '0; end
              C_RST_TB: begin rf_we = 1'b1; rf_row = ROW_M2; rf_col = 3'd1; rf_wd = '0; end
              C_LOAD: begin
                frdy_n = 1'b0;
                wa_n   = {cfg.a_hi, cfg.a_lo};
                wb_n   = {cfg.b_hi, cfg.b_lo};
                wc_n   = {cfg.len_hi, cfg.len_lo};
                stat_n = stat_q | 8'h30;
              end
              C_CONT: begin
                wc_n   = {cfg.len_hi, cfg.len_lo};
                en_n   = 1'b1;
                stat_n = stat_q | 8'h30;
              end
              C_DIS:    ;
              C_NOP:    ;
              C_EN:     en_n = 1'b1;
              C_FRDY:   frdy_n = 1'b1;
              C_REINIT: stat_n = stat_q | 8'h30;
              C_IEN: begin
                rf_we = 1'b1; rf_row = ROW_M3; rf_wd = cfg.base[3] | 8'h20;
              end
              C_IDIS: begin
                rf_we = 1'b1; rf_row = ROW_M3; rf_wd = cfg.base[3] & ~8'h20;
              end
              C_IRDIS: begin
                rf_we = 1'b1; rf_row = ROW_M3; rf_wd = cfg.base[3] & ~8'h20;
                frdy_n = 1'b0; stat_n = stat_q | 8'h08;
              end
              C_RDSEQ:  rq_load = 1'b1;
              C_RMASK: begin
                pend_row_n = ROW_CMD; pend_mask_n[1] = 1'b1;
              end
              C_RDSTAT: begin
                rf_we = 1'b1; rf_row = ROW_CMD; rf_col = 3'd1; rf_wd = '0;
              end
              default:  err_n = 1'b1;
            endcase
          end
          K_BAD: err_n = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_row  <= '0;
      pend_mask <= '0;
      rptr      <= '0;
      stat_q    <= '0;
      en_q      <= 1'b0;
      frdy_q    <= 1'b0;
      err_q     <= 1'b0;
      wa_q      <= '0;
      wb_q      <= '0;
      wc_q      <= '0;
    end else begin
      pend_row  <= pend_row_n;
      pend_mask <= pend_mask_n;
      rptr      <= rptr_n;
      stat_q    <= stat_n;
      en_q      <= en_n;
      frdy_q    <= frdy_n;
      err_q     <= err_n;
      wa_q      <= wa_n;
      wb_q      <= wb_n;
      wc_q      <= wc_n;
    end
  end

  assign dma_enable  = en_q;
  assign force_ready = frdy_q;
  assign irq_enable  = cfg.base[3][5];
  assign cmd_error   = err_q;
  assign status      = stat_q;
  assign work_addr_a = wa_q;
  assign work_addr_b = wb_q;
  assign work_count  = wc_q;
  assign mode_regs   = cfg.base;
  assign timing_a    = cfg.tim_a;
  assign timing_b    = cfg.tim_b;
  assign mask_byte   = cfg.msk;
  assign match_byte  = cfg.mtc;
  assign int_ctrl    = cfg.ictl;
  assign pulse_ctrl  = cfg.pulse;
  assign int_vector  = cfg.vec;

  // R6
  cmd_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && kind == K_CMD && wr_data != C_EN && wr_data != C_CONT)
      |=> !dma_enable);
  // R7
  load_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wr_data == C_LOAD)
      |=> (status[5:4] == 2'b11 && !force_ready &&
           work_count == $past({cfg.len_hi, cfg.len_lo})));
  // R9
  reset_status_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wr_data == C_RESET) |=> (status == 8'h38 && !force_ready));
  // R9
  rptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    rptr < CW'(NCOL));
  // R5
  ictl_replace_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy && pend_row == ROW_M4 && pcol == COL_ICTL)
      |=> (pend_mask[COL_ICTL:0] == '0));
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_error |=> cmd_error);
endmodule

// File: tb/dma_regseq_tb_top.sv
`timescale 1ns/1ps
module dma_regseq_tb_top;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data, status, timing_a, timing_b, mask_byte, match_byte;
  logic [7:0]  int_ctrl, pulse_ctrl, int_vector;
  logic        dma_enable, force_ready, irq_enable, cmd_error;
  logic [15:0] work_addr_a, work_addr_b, work_count;
  logic [47:0] mode_regs;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  dma_regseq dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .dma_enable(dma_enable), .force_ready(force_ready),
    .irq_enable(irq_enable), .cmd_error(cmd_error), .status(status),
    .work_addr_a(work_addr_a), .work_addr_b(work_addr_b), .work_count(work_count),
    .mode_regs(mode_regs), .timing_a(timing_a), .timing_b(timing_b),
    .mask_byte(mask_byte), .match_byte(match_byte), .int_ctrl(int_ctrl),
    .pulse_ctrl(pulse_ctrl), .int_vector(int_vector)
  );

  // {is_read, byte, expected read value}
  localparam int NV = 20;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h79, 8'h00}, {1'b0, 8'h34, 8'h00}, {1'b0, 8'h12, 8'h00},
    {1'b0, 8'h05, 8'h00}, {1'b0, 8'h00, 8'h00}, {1'b0, 8'h8D, 8'h00},
    {1'b0, 8'h78, 8'h00}, {1'b0, 8'h56, 8'h00}, {1'b0, 8'hCF, 8'h00},
    {1'b0, 8'hBB, 8'h00}, {1'b0, 8'h7F, 8'h00}, {1'b0, 8'hA7, 8'h00},
    {1'b1, 8'h00, 8'h30}, {1'b1, 8'h00, 8'h05}, {1'b1, 8'h00, 8'h00},
    {1'b1, 8'h00, 8'h34}, {1'b1, 8'h00, 8'h12}, {1'b1, 8'h00, 8'h78},
    {1'b1, 8'h00, 8'h56}, {1'b1, 8'h00, 8'h30}
  };

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R14 reset state
    chk("R14 status", status, 8'h00);
    chk("R14 flags", {dma_enable, force_ready, irq_enable, cmd_error}, 4'h0);
    chk("R14 counters", {work_addr_a, work_addr_b, work_count}, 48'h0);
    chk("R14 mode", mode_regs, 48'h0);
    rd(v); chk("R14 empty queue", v, 8'h00);

    // table: program, load, read back (R2 R4 R7 R11)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) begin
        rd(v); chk($sformatf("R11 table row %0d", i), v, VEC[i][7:0]);
      end else begin
        wr(VEC[i][15:8]);
      end
    end
    chk("R2 port A address", work_addr_a, 16'h1234);
    chk("R4 port B address", work_addr_b, 16'h5678);
    chk("R7 count", work_count, 16'h0005);
    chk("R7 status", status, 8'h30);

    // R10 interrupt commands
    wr(8'hA3); chk("R10 status or 08", status, 8'h38);
    wr(8'hAB); chk("R10 irq set", irq_enable, 1'b1);
    wr(8'hAF); chk("R10 irq clear", irq_enable, 1'b0);

    // R1 R3 decode and timing bytes
    wr(8'h44); wr(8'hA5); chk("R3 timing A", timing_a, 8'hA5);
    wr(8'h40); wr(8'h5A); chk("R3 timing B", timing_b, 8'h5A);
    wr(8'h00); chk("R1 mode2 byte", mode_regs[16 +: 8], 8'h00);
    wr(8'hAB); chk("R1 next is command", irq_enable, 1'b1);
    chk("R1 timing B untouched", timing_b, 8'h5A);
    wr(8'h04); chk("R1 mode1 byte", mode_regs[8 +: 8], 8'h04);
    wr(8'hAF);

    // R4 mask and match
    wr(8'h98); wr(8'h11); wr(8'h22);
    chk("R4 mask", mask_byte, 8'h11); chk("R4 match", match_byte, 8'h22);
    wr(8'h90); wr(8'h33);
    chk("R4 match only", match_byte, 8'h33); chk("R4 mask kept", mask_byte, 8'h11);

    // R5 interrupt control extension
    wr(8'h91); wr(8'h18); wr(8'h66); wr(8'h77);
    chk("R5 ictl", int_ctrl, 8'h18); chk("R5 pulse", pulse_ctrl, 8'h66);
    chk("R5 vector", int_vector, 8'h77);
    wr(8'h87); chk("R5 list ended", dma_enable, 1'b1);
    wr(8'h95); wr(8'h9A); wr(8'h10); wr(8'h44);
    chk("R5 vector only", int_vector, 8'h44); chk("R5 pulse kept", pulse_ctrl, 8'h66);
    chk("R5 ictl 2", int_ctrl, 8'h10);

    // R6 enable and force ready
    wr(8'hB3); chk("R6 force clears enable", {dma_enable, force_ready}, 2'b01);
    wr(8'h87); chk("R6 enable", {dma_enable, force_ready}, 2'b11);
    wr(8'h83); chk("R6 disable", dma_enable, 1'b0);
    wr(8'h87); wr(8'h8B); chk("R6 any command clears", dma_enable, 1'b0);

    // R7 load clears force ready
    wr(8'hCF);
    chk("R7 force cleared", force_ready, 1'b0);
    chk("R7 B address", work_addr_b, 16'h569A);

    // R8 continue
    wr(8'h29); wr(8'hEE); wr(8'h09); wr(8'hD3);
    chk("R8 count", work_count, 16'h0009);
    chk("R8 A unchanged", work_addr_a, 16'h1234);
    chk("R8 enable", dma_enable, 1'b1);

    // R9 column sweep
    wr(8'h44); wr(8'hA5);
    wr(8'hC3);
    chk("R9 status", status, 8'h38); chk("R9 enable", dma_enable, 1'b0);
    chk("R9 col1", {timing_a, timing_b, mask_byte}, 24'h0);
    chk("R9 col2 kept", match_byte, 8'h33);
    wr(8'hC3); chk("R9 col2", match_byte, 8'h00); chk("R9 col3 kept", int_ctrl, 8'h10);
    wr(8'hC3); chk("R9 col3", int_ctrl, 8'h00); chk("R9 col4 kept", pulse_ctrl, 8'h66);
    chk("R9 mode kept", mode_regs[7:0], 8'h29);
    wr(8'hC3); chk("R9 col4", pulse_ctrl, 8'h00);
    wr(8'hC3); chk("R9 col5", int_vector, 8'h00);
    wr(8'hC3); chk("R9 col0 wrap", mode_regs, 48'h0);

    // R13 timing resets
    wr(8'h44); wr(8'hA5); wr(8'h40); wr(8'h5A);
    wr(8'hC7); chk("R13 timing A cleared", {timing_a, timing_b}, 16'h005A);
    wr(8'hCB); chk("R13 timing B cleared", timing_b, 8'h00);

    // R12 error handling
    wr(8'h87); wr(8'hFB); chk("R12 nop", {dma_enable, cmd_error}, 2'b00);
    wr(8'hB7); chk("R12 unlisted", cmd_error, 1'b1);
    wr(8'h87); chk("R12 sticky", {dma_enable, cmd_error}, 2'b11);
    do_reset(); chk("R14 error cleared", cmd_error, 1'b0);
    wr(8'h86); chk("R12 bad base", cmd_error, 1'b1);
    do_reset();
    wr(8'h8B); chk("R13 reinit", status, 8'h30);

    // R11 same-cycle read and write
    do_reset();
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hCF; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 read sees old status", rd_data, 8'h00);
    rd(v); chk("R11 read sees new status", v, 8'h30);
    wr(8'hBB); wr(8'h01); wr(8'hB3);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hA7; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 read before queue built", rd_data, 8'h30);
    wr(8'hCB);
    rd(v); chk("R11 queued status", v, 8'h30);
    wr(8'hBF); wr(8'hA7); wr(8'hA3);
    rd(v); chk("R11 cleared mask falls back", v, 8'h38);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule